// File: doc/BRIEF.md
# 8x8 Forward DCT Engine

This block takes an 8x8 tile of signed 16-bit residual samples and produces the 64 coefficients of its two-dimensional forward discrete cosine transform. The tile arrives one row per beat on a valid/ready input. Every sample is multiplied by four before any arithmetic. The rows are collected in a 64-entry register buffer. A single combinational eight-point butterfly is then used twice. In the first pass it walks the buffer column by column and writes each result back into the column it read. In the second pass it walks the buffer row by row, and each result, halved toward zero, leaves as one output row.

The source of the rows may use any memory stride. Only the order matters, with row 0 first. The output tile is dense: output row k holds coefficients k*8 to k*8+7. The engine handles one tile at a time and takes no new row until the last output row of the current tile has been accepted.

Top module: `fdct8x8`

## Requirements
- R1: While reset is asserted and right after it, `in_ready_o` is 1 and both `out_valid_o` and `out_last_o` are 0.
- R2: Each input sample is multiplied by 4 modulo 2^16 before the transform. For example, a tile of all 16384 turns into zeros and gives an all-zero result.
- R3: Lane j of a row sits at bits [16j+15:16j]. Output row k, lane j equals the bit-exact two-pass result. Pass 1 runs the eight-point butterfly down each column c and gives coefficient k for column c. Pass 2 runs the butterfly along the row of pass-1 coefficient k and gives lane j. The butterfly uses 16-bit wrapping sums. Its products are formed at full width with the constants 16069, 15137, 13623, 11585, 9102, 6270 and 3196. Each product is narrowed by adding 8192, shifting right by 14 and keeping the low 16 bits.
- R4: Every coefficient leaving the engine is the pass-2 value n halved with rounding toward zero, computed as (n + 1) >> 1 when n is negative and n >> 1 otherwise.
- R5: From the beat that closes a tile until the last output row is accepted, `in_ready_o` is 0, and rows offered during that time are not taken.
- R6: After the clock edge that accepts the closing row, `out_valid_o` rises exactly 8 clock edges later.
- R7: `out_last_o` is 1 only on output row 7. While `out_valid_o` is 1 and `out_ready_i` is 0, the output row, `out_last_o` and `out_valid_o` hold their values.
- R8: A row accepted with `in_last_i` = 1 closes the tile, and every row not yet received counts as zero. The eighth row closes the tile even when `in_last_i` is 0.
- R9: The cycle after output row 7 is accepted, `in_ready_o` is 1 and `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input row is valid |
| in_ready_o | output | 1 | Engine accepts an input row |
| in_row_i | input | 128 | Eight signed 16-bit samples, lane j at bits [16j+15:16j] |
| in_last_i | input | 1 | This row closes the tile |
| out_valid_o | output | 1 | Output row is valid |
| out_ready_i | input | 1 | Consumer accepts the output row |
| out_row_o | output | 128 | Eight signed 16-bit coefficients, lane j at bits [16j+15:16j] |
| out_last_o | output | 1 | Output row 7 of the tile |

## Verification
Two buffer operations can happen in the same cycle. In pass 1, one column is read and the butterfly result is written back into that same column on the same edge. When a row arrives with the early last flag, that row is written while every row below it is cleared. The in-place column update runs on every tile. Tiles whose rows and columns differ strongly, random and extreme, would expose a column index that is off by one or a write that lands before its read. A tile closed after three rows provokes the write-and-clear case. Both are judged by comparing every output row bit for bit against an integer model of the same two-pass arithmetic, with the missing rows set to zero.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int W     = 16;
  localparam int N     = 8;
  localparam int IW    = $clog2(N);
  localparam int ROW_W = N * W;
  localparam int PRE   = 2;
  localparam int CB    = 14;
  localparam int AW    = 2 * W + 1;

  localparam int K4  = 16069;
  localparam int K8  = 15137;
  localparam int K12 = 13623;
  localparam int K16 = 11585;
  localparam int K20 = 9102;
  localparam int K24 = 6270;
  localparam int K28 = 3196;

  typedef logic signed [W-1:0]  smp_t;
  typedef logic signed [AW-1:0] acc_t;

  function automatic acc_t widen(smp_t a);
    return acc_t'(a);
  endfunction

  function automatic acc_t mulk(acc_t a, int k);
    return a * acc_t'(k);
  endfunction

  function automatic smp_t narrow(acc_t v);
    acc_t t;
    t = v + acc_t'(1 << (CB - 1));
    return smp_t'(t[CB+W-1:CB]);
  endfunction

  function automatic smp_t halve(smp_t n);
    logic signed [W:0] t;
    t = {n[W-1], n} + {{W{1'b0}}, n[W-1]};
    return smp_t'(t[W:1]);
  endfunction
endpackage

// File: rtl/fdct_bfly8.sv
module fdct_bfly8
  import fdct_pkg::*;
(
  input  logic [ROW_W-1:0] x_i,
  output logic [ROW_W-1:0] y_o
);
  smp_t v [N];
  smp_t o [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign v[g] = x_i[g*W +: W];
    assign y_o[g*W +: W] = o[g];
  end

  smp_t s0, s1, s2, s3, s4, s5, s6, s7;
  smp_t e0, e1, e2, e3;
  smp_t m0, m1;
  smp_t u0, u1, u2, u3;

  assign s0 = v[0] + v[7];
  assign s1 = v[1] + v[6];
  assign s2 = v[2] + v[5];
  assign s3 = v[3] + v[4];
  assign s4 = v[3] - v[4];
  assign s5 = v[2] - v[5];
  assign s6 = v[1] - v[6];
  assign s7 = v[0] - v[7];

  // even half
  assign e0 = s0 + s3;
  assign e1 = s1 + s2;
  assign e2 = s1 - s2;
  assign e3 = s0 - s3;

  assign o[0] = narrow(mulk(widen(e0) + widen(e1), K16));
  assign o[4] = narrow(mulk(widen(e0) - widen(e1), K16));
  assign o[2] = narrow(mulk(widen(e2), K24) + mulk(widen(e3), K8));
  assign o[6] = narrow(mulk(widen(e3), K24) - mulk(widen(e2), K8));

  // odd half
  assign m0 = narrow(mulk(widen(smp_t'(s6 - s5)), K16));
  assign m1 = narrow(mulk(widen(smp_t'(s6 + s5)), K16));
  assign u0 = s4 + m0;
  assign u1 = s4 - m0;
  assign u2 = s7 - m1;
  assign u3 = s7 + m1;

  assign o[1] = narrow(mulk(widen(u3), K4)  + mulk(widen(u0), K28));
  assign o[5] = narrow(mulk(widen(u1), K12) + mulk(widen(u2), K20));
  assign o[3] = narrow(mulk(widen(u2), K12) - mulk(widen(u1), K20));
  assign o[7] = narrow(mulk(widen(u3), K28) - mulk(widen(u0), K4));
endmodule

// File: rtl/fdct_tbuf.sv
module fdct_tbuf
  import fdct_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_we_i,
  input  logic             fill_i,
  input  logic [IW-1:0]    row_idx_i,
  input  logic [ROW_W-1:0] row_d_i,
  input  logic             col_we_i,
  input  logic [IW-1:0]    col_idx_i,
  input  logic [ROW_W-1:0] col_d_i,
  output logic [ROW_W-1:0] col_q_o,
  output logic [ROW_W-1:0] row_q_o
);
  smp_t mem [N][N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          mem[r][c] <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          if (row_we_i && r == int'(row_idx_i))
            mem[r][c] <= row_d_i[c*W +: W];
          else if (row_we_i && fill_i && r > int'(row_idx_i))
            mem[r][c] <= '0;
          else if (col_we_i && c == int'(col_idx_i))
            mem[r][c] <= col_d_i[r*W +: W];
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rd
    assign col_q_o[g*W +: W] = mem[g][col_idx_i];
    assign row_q_o[g*W +: W] = mem[row_idx_i][g];
  end
endmodule

// File: rtl/fdct_ctrl.sv
module fdct_ctrl
  import fdct_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_last_i,
  input  logic          out_ready_i,
  output logic          in_ready_o,
  output logic          load_o,
  output logic          pass_o,
  output logic          out_valid_o,
  output logic          out_last_o,
  output logic [IW-1:0] idx_o
);
  typedef enum logic [1:0] {ST_LOAD, ST_PASS, ST_DRAIN} st_e;

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  st_e           state;
  logic [IW-1:0] cnt;
  logic          close;

  assign in_ready_o  = (state == ST_LOAD);
  assign load_o      = in_ready_o && in_valid_i;
  assign close       = load_o && (in_last_i || cnt == LAST);
  assign pass_o      = (state == ST_PASS);
  assign out_valid_o = (state == ST_DRAIN);
  assign out_last_o  = out_valid_o && (cnt == LAST);
  assign idx_o       = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (close) begin
            state <= ST_PASS;
            cnt   <= '0;
          end else if (load_o) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PASS: begin
          if (cnt == LAST) begin
            state <= ST_DRAIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (out_ready_i) begin
            if (cnt == LAST) begin
              state <= ST_LOAD;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fdct8x8.sv
module fdct8x8
  import fdct_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ROW_W-1:0] in_row_i,
  input  logic             in_last_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [ROW_W-1:0] out_row_o,
  output logic             out_last_o
);
  logic          load, pass;
  logic [IW-1:0] idx;
  logic [ROW_W-1:0] pre_row, col_q, row_q, bf_in, bf_out;

  fdct_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .pass_o      (pass),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .idx_o       (idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_pre
    assign pre_row[g*W +: W] = in_row_i[g*W +: W] << PRE;
  end

  // pass 1 updates columns in place; pass 2 reads rows
  fdct_tbuf u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_we_i  (load),
    .fill_i    (in_last_i),
    .row_idx_i (idx),
    .row_d_i   (pre_row),
    .col_we_i  (pass),
    .col_idx_i (idx),
    .col_d_i   (bf_out),
    .col_q_o   (col_q),
    .row_q_o   (row_q)
  );

  assign bf_in = pass ? col_q : row_q;

  fdct_bfly8 u_bfly (
    .x_i (bf_in),
    .y_o (bf_out)
  );

  for (genvar g = 0; g < N; g++) begin : g_half
    assign out_row_o[g*W +: W] = halve(bf_out[g*W +: W]);
  end
endmodule

// File: rtl/fdct8x8_chk.sv
module fdct8x8_chk
  import fdct_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             in_last_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [ROW_W-1:0] out_row_o,
  input logic             out_last_o
);
  localparam int LAT = N + 1;

  logic       in_hs, out_hs, close;
  logic [3:0] acc_cnt;
  logic [3:0] out_cnt;
  logic [4:0] lat;

  assign in_hs  = in_valid_i && in_ready_o;
  assign out_hs = out_valid_o && out_ready_i;
  assign close  = in_hs && (in_last_i || int'(acc_cnt) == N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt <= '0;
      out_cnt <= '0;
      lat     <= '0;
    end else begin
      if (close)      acc_cnt <= '0;
      else if (in_hs) acc_cnt <= acc_cnt + 1'b1;
      if (out_hs) out_cnt <= out_last_o ? 4'd0 : out_cnt + 1'b1;
      if (close)           lat <= 5'd1;
      else if (lat != '0)  lat <= (int'(lat) == LAT) ? 5'd0 : lat + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> in_ready_o && !out_valid_o && !out_last_o);

  assert_busy_no_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_close_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |=> !in_ready_o);

  assert_latency_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat != '0 && int'(lat) < LAT) |-> !out_valid_o);

  assert_latency_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lat) == LAT) |-> out_valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_row_o) && $stable(out_last_o));

  assert_last_pos_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (int'(out_cnt) == N - 1)));

  assert_reopen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hs && out_last_o |=> in_ready_o && !out_valid_o);
endmodule

bind fdct8x8 fdct8x8_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_last_i   (in_last_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_row_o   (out_row_o),
  .out_last_o  (out_last_o)
);

// File: tb/fdct8x8_tb.sv
`timescale 1ns/1ps
module fdct8x8_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         in_valid_i;
  logic         in_ready_o;
  logic [127:0] in_row_i;
  logic         in_last_i;
  logic         out_valid_o;
  logic         out_ready_i;
  logic [127:0] out_row_o;
  logic         out_last_o;

  always #5 clk_i = ~clk_i;

  fdct8x8 u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_row_i    (in_row_i),
    .in_last_i   (in_last_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_row_o   (out_row_o),
    .out_last_o  (out_last_o)
  );

  int n_run = 0;
  int n_fail = 0;
  int cur [8][8];
  logic [127:0] exp_rows [8];

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  function automatic int w16(int v);
    return int'(shortint'(v));
  endfunction

  function automatic int rnd(int v);
    return w16((v + 8192) >>> 14);
  endfunction

  function automatic int hlv(int n);
    return (n < 0) ? ((n + 1) >>> 1) : (n >>> 1);
  endfunction

  function automatic void dct8(input int i[8], output int o[8]);
    int s0, s1, s2, s3, s4, s5, s6, s7, e0, e1, e2, e3, m0, m1, u0, u1, u2, u3;
    s0 = w16(i[0] + i[7]); s1 = w16(i[1] + i[6]);
    s2 = w16(i[2] + i[5]); s3 = w16(i[3] + i[4]);
    s4 = w16(i[3] - i[4]); s5 = w16(i[2] - i[5]);
    s6 = w16(i[1] - i[6]); s7 = w16(i[0] - i[7]);
    e0 = w16(s0 + s3); e1 = w16(s1 + s2); e2 = w16(s1 - s2); e3 = w16(s0 - s3);
    o[0] = rnd((e0 + e1) * 11585);
    o[4] = rnd((e0 - e1) * 11585);
    o[2] = rnd(e2 * 6270 + e3 * 15137);
    o[6] = rnd(e3 * 6270 - e2 * 15137);
    m0 = rnd(w16(s6 - s5) * 11585);
    m1 = rnd(w16(s6 + s5) * 11585);
    u0 = w16(s4 + m0); u1 = w16(s4 - m0); u2 = w16(s7 - m1); u3 = w16(s7 + m1);
    o[1] = rnd(u3 * 16069 + u0 * 3196);
    o[5] = rnd(u1 * 13623 + u2 * 9102);
    o[3] = rnd(u2 * 13623 - u1 * 9102);
    o[7] = rnd(u3 * 3196 - u0 * 16069);
  endfunction

  function automatic logic [127:0] pack(input int v[8]);
    logic [127:0] p;
    for (int j = 0; j < 8; j++) p[j*16 +: 16] = 16'(v[j]);
    return p;
  endfunction

  // model: rows at or beyond nrows are zero
  task automatic build_expect(int nrows);
    int p [8][8];
    int y1 [8][8];
    int vin [8];
    int vout [8];
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        p[r][c] = (r < nrows) ? w16(cur[r][c] * 4) : 0;
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 8; r++) vin[r] = p[r][c];
      dct8(vin, vout);
      for (int k = 0; k < 8; k++) y1[k][c] = vout[k];
    end
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 8; c++) vin[c] = y1[k][c];
      dct8(vin, vout);
      for (int j = 0; j < 8; j++) vout[j] = hlv(vout[j]);
      exp_rows[k] = pack(vout);
    end
  endtask

  // rdy_mode: 0 always, 1 alternate, 2 random
  task automatic run_block(int nrows, bit use_last, int rdy_mode, bit garbage, string tag);
    int vrow [8];
    int n;
    int k;
    bit held;
    bit rdy;
    logic [127:0] held_row;
    logic held_last;
    build_expect(nrows);
    for (int r = 0; r < nrows; r++) begin
      @(negedge clk_i);
      for (int c = 0; c < 8; c++) vrow[c] = cur[r][c];
      in_valid_i = 1'b1;
      in_row_i   = pack(vrow);
      in_last_i  = use_last && (r == nrows - 1);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    n = 0;
    @(negedge clk_i);
    in_valid_i = garbage;
    in_row_i   = {8{16'h7ff5}};
    in_last_i  = garbage;
    while (!out_valid_o) begin
      if (garbage) chk(!in_ready_o, "R5", {tag, " ready low in pass"}, 128'(in_ready_o), 128'(0));
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
    end
    chk(n == 8, "R6", {tag, " latency"}, 128'(n), 128'(8));
    k = 0;
    held = 1'b0;
    held_row = '0;
    held_last = 1'b0;
    while (k < 8) begin
      case (rdy_mode)
        0: rdy = 1'b1;
        1: rdy = held;
        default: rdy = 1'($urandom);
      endcase
      out_ready_i = rdy;
      if (garbage) chk(!in_ready_o, "R5", {tag, " ready low in drain"}, 128'(in_ready_o), 128'(0));
      chk(out_valid_o, "R7", {tag, " valid held"}, 128'(out_valid_o), 128'(1));
      if (held) begin
        chk(out_row_o == held_row, "R7", {tag, " row stable"}, out_row_o, held_row);
        chk(out_last_o == held_last, "R7", {tag, " last stable"}, 128'(out_last_o), 128'(held_last));
      end
      if (rdy) begin
        chk(out_row_o == exp_rows[k], "R3 R4", $sformatf("%s row %0d", tag, k), out_row_o, exp_rows[k]);
        chk(out_last_o == (k == 7), "R7", $sformatf("%s last at row %0d", tag, k),
            128'(out_last_o), 128'(k == 7));
        if (k == 7) in_valid_i = 1'b0;
        k++;
        held = 1'b0;
      end else begin
        held = 1'b1;
        held_row = out_row_o;
        held_last = out_last_o;
      end
      @(posedge clk_i);
      @(negedge clk_i);
    end
    out_ready_i = 1'b0;
    in_valid_i  = 1'b0;
    in_last_i   = 1'b0;
    chk(in_ready_o && !out_valid_o, "R9", {tag, " reopen"}, {in_ready_o, out_valid_o}, 128'b10);
  endtask

  task automatic fill_const(int v);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) cur[r][c] = v;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0; in_row_i = '0; in_last_i = 1'b0; out_ready_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(in_ready_o && !out_valid_o && !out_last_o, "R1", "in reset",
        {in_ready_o, out_valid_o, out_last_o}, 128'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o && !out_valid_o && !out_last_o, "R1", "after reset",
        {in_ready_o, out_valid_o, out_last_o}, 128'b100);
  endtask

  task automatic t_zero();
    fill_const(0);
    run_block(8, 1'b1, 0, 1'b0, "zero");
  endtask

  task automatic t_wrap();
    fill_const(16384);
    build_expect(8);
    chk(exp_rows[0] == '0, "R2", "model wrap", exp_rows[0], '0);
    run_block(8, 1'b1, 0, 1'b0, "R2 wrap16384");
  endtask

  task automatic t_random();
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          cur[r][c] = (b < 2) ? w16(int'($urandom)) : (int'($urandom_range(510)) - 255);
      run_block(8, 1'b1, 0, 1'b0, "random");
    end
  endtask

  task automatic t_extreme();
    fill_const(32767);
    run_block(8, 1'b1, 0, 1'b0, "R2 max");
    fill_const(-32768);
    run_block(8, 1'b1, 0, 1'b0, "R2 min");
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        cur[r][c] = ((r + c) % 2 == 0) ? 8191 : -8192;
    run_block(8, 1'b1, 0, 1'b0, "R4 checker");
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        cur[r][c] = (c == 0) ? -(r * 1000 + 1) : r - c;
    run_block(8, 1'b1, 0, 1'b0, "R4 asym");
  endtask

  task automatic t_backpressure();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) cur[r][c] = w16(int'($urandom));
    run_block(8, 1'b1, 1, 1'b0, "R7 alt");
    run_block(8, 1'b1, 2, 1'b0, "R7 rand");
  endtask

  task automatic t_busy();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) cur[r][c] = r * 37 - c * 91;
    run_block(8, 1'b1, 2, 1'b1, "R5 busy");
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) cur[r][c] = c * 53 - r * 11;
    run_block(8, 1'b1, 0, 1'b0, "R5 after busy");
  endtask

  task automatic t_short();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) cur[r][c] = 1000 + r * 100 + c;
    run_block(3, 1'b1, 0, 1'b0, "R8 early last");
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) cur[r][c] = -(r * 13) + c * 7;
    run_block(8, 1'b0, 0, 1'b0, "R8 no last");
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_wrap();
    t_random();
    t_extreme();
    t_backpressure();
    t_busy();
    t_short();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule